// File: doc/BRIEF.md
# Packed Quad-Byte Multiply Unit

This execution unit serves a single coprocessor instruction that multiplies four byte lanes in parallel. It takes the instruction word and a valid strobe, decodes two source indices and two destination indices, and expects the two 32-bit operand values to arrive in the same cycle from a 16-entry extension register file. Each byte of the first operand is multiplied by the byte in the same lane of the second operand. Only the low 16 bits of each lane product are kept.

The four 16-bit products are packed into two 32-bit words. The lower two lanes go to one destination and the upper two lanes go to the other. A 4-bit selector field picks whether the first operand's bytes are treated as signed. The second operand's bytes are always unsigned. The results are registered for one clock and appear on two write-back ports, each with its own index, data and enable.

The register file, instruction fetch and the other extension instructions are not part of this unit.

Top module: `qmul_unit`

## Requirements
- R1: An instruction is accepted only when `valid_i` is high, bits 31:26 equal 0x1C and bits 5:0 equal 0x38. In every other case no write enable asserts in the following cycle.
- R2: Both write enables assert in exactly the cycle after an accepted instruction and are low in every other cycle.
- R3: The index fields are fixed in the instruction word: first destination at bits 9:6, first source at bits 13:10, second source at bits 17:14, second destination at bits 21:18 and selector at bits 25:22. `srcb_idx_o` and `srcc_idx_o` follow the source fields combinationally. `wa_idx_o` and `wd_idx_o` carry the destination fields of the accepted instruction.
- R4: When the selector equals 2, each byte of `opb_i` is sign-extended before it is multiplied. For any other selector value it is zero-extended.
- R5: Each byte of `opc_i` is always zero-extended, whatever the selector value.
- R6: Lane i multiplies `opb_i[8i+7:8i]` by `opc_i[8i+7:8i]`. Only the low 16 bits of each product are kept.
- R7: `wd_data_o` holds the lane 1 product in bits 31:16 and the lane 0 product in bits 15:0.
- R8: `wa_data_o` holds the lane 3 product in bits 31:16 and the lane 2 product in bits 15:0.
- R9: When the two destination indices are equal, only `wa_en_o` asserts, so the upper-lane word is the value that remains in that register.
- R10: While `rst_ni` is low, both write enables and both write data words are 0.
- R11: Results come only from the operands present in the accept cycle. Both write data words hold their values until the next accepted instruction, whatever `opb_i` and `opc_i` do in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| opb_i | input | 32 | Value of the first source register |
| opc_i | input | 32 | Value of the second source register |
| srcb_idx_o | output | 4 | Register-file read index for the first source |
| srcc_idx_o | output | 4 | Register-file read index for the second source |
| wa_en_o | output | 1 | Write enable, upper-lane destination |
| wa_idx_o | output | 4 | Write index, upper-lane destination |
| wa_data_o | output | 32 | Packed products of lanes 3 and 2 |
| wd_en_o | output | 1 | Write enable, lower-lane destination |
| wd_idx_o | output | 4 | Write index, lower-lane destination |
| wd_data_o | output | 32 | Packed products of lanes 1 and 0 |

## Verification
The bench drives the byte values 0x00, 0x7F, 0x80 and 0xFF into every lane of both operands under the signed selector and under an unsigned one. A design that extended the wrong operand, or that extended on the wrong selector value, gives wrong upper product bits at 0x80 and 0xFF. A design that did not truncate to 16 bits has nowhere to hide 0xFF times 0xFF.

Every selector value from 0 to 15 is swept, so a decoder that tested only some selector bits is caught. Instructions whose major opcode or function field is one step off must produce no write. Issuing with equal destination indices exposes a design that lets the lower-lane word write too. Changing the operands while the unit is idle exposes outputs that follow the inputs instead of holding the registered result.

// File: rtl/qmul_pkg.sv
package qmul_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned LANES    = XLEN / LANE_W;
  localparam int unsigned PROD_W   = 2 * LANE_W;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned OP_W     = 6;

  localparam logic [OP_W-1:0]  MAJOR_OP   = 6'h1C;
  localparam logic [OP_W-1:0]  FUNC_OP    = 6'h38;
  localparam logic [SEL_W-1:0] SEL_SIGNED = 4'd2;

  localparam int unsigned DA_LSB  = 6;
  localparam int unsigned SB_LSB  = 10;
  localparam int unsigned SC_LSB  = 14;
  localparam int unsigned DD_LSB  = 18;
  localparam int unsigned SEL_LSB = 22;
  localparam int unsigned MAJ_LSB = 26;

  typedef struct packed {
    logic             hit;
    logic             b_signed;
    logic [IDX_W-1:0] da;
    logic [IDX_W-1:0] sb;
    logic [IDX_W-1:0] sc;
    logic [IDX_W-1:0] dd;
  } dec_t;
endpackage

// File: rtl/qmul_decode.sv
module qmul_decode
  import qmul_pkg::*;
(
  input  logic            valid_i,
  input  logic [XLEN-1:0] instr_i,
  output dec_t            dec_o
);
  logic [OP_W-1:0]  major;
  logic [OP_W-1:0]  func;
  logic [SEL_W-1:0] sel;

  assign major = instr_i[MAJ_LSB +: OP_W];
  assign func  = instr_i[0 +: OP_W];
  assign sel   = instr_i[SEL_LSB +: SEL_W];

  always_comb begin
    dec_o.hit      = valid_i && (major == MAJOR_OP) && (func == FUNC_OP);
    dec_o.b_signed = (sel == SEL_SIGNED);
    dec_o.da       = instr_i[DA_LSB +: IDX_W];
    dec_o.sb       = instr_i[SB_LSB +: IDX_W];
    dec_o.sc       = instr_i[SC_LSB +: IDX_W];
    dec_o.dd       = instr_i[DD_LSB +: IDX_W];
  end
endmodule

// File: rtl/qmul_lane.sv
module qmul_lane #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned PROD_W = 16,
  localparam int unsigned EXT_W  = LANE_W + 1,
  localparam int unsigned FULL_W = 2 * EXT_W
) (
  input  logic [LANE_W-1:0] b_i,
  input  logic [LANE_W-1:0] c_i,
  input  logic              b_signed_i,
  output logic [PROD_W-1:0] prod_o
);
  logic signed [EXT_W-1:0]  b_ext;
  logic signed [EXT_W-1:0]  c_ext;
  logic signed [FULL_W-1:0] full;

  // c is never signed; its extension bit is always 0
  assign b_ext  = {b_signed_i & b_i[LANE_W-1], b_i};
  assign c_ext  = {1'b0, c_i};
  assign full   = FULL_W'(b_ext) * FULL_W'(c_ext);
  assign prod_o = full[PROD_W-1:0];
endmodule

// File: rtl/qmul_wb_reg.sv
module qmul_wb_reg
  import qmul_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  dec_t             dec_i,
  input  logic [XLEN-1:0]  res_a_i,
  input  logic [XLEN-1:0]  res_d_i,
  output logic             wa_en_o,
  output logic [IDX_W-1:0] wa_idx_o,
  output logic [XLEN-1:0]  wa_data_o,
  output logic             wd_en_o,
  output logic [IDX_W-1:0] wd_idx_o,
  output logic [XLEN-1:0]  wd_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wa_en_o   <= 1'b0;
      wd_en_o   <= 1'b0;
      wa_idx_o  <= '0;
      wd_idx_o  <= '0;
      wa_data_o <= '0;
      wd_data_o <= '0;
    end else begin
      wa_en_o <= dec_i.hit;
      // same destination: only the upper-lane word is written
      wd_en_o <= dec_i.hit && (dec_i.da != dec_i.dd);
      if (dec_i.hit) begin
        wa_idx_o  <= dec_i.da;
        wd_idx_o  <= dec_i.dd;
        wa_data_o <= res_a_i;
        wd_data_o <= res_d_i;
      end
    end
  end
endmodule

// File: rtl/qmul_unit.sv
module qmul_unit
  import qmul_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [XLEN-1:0]  instr_i,
  input  logic [XLEN-1:0]  opb_i,
  input  logic [XLEN-1:0]  opc_i,
  output logic [IDX_W-1:0] srcb_idx_o,
  output logic [IDX_W-1:0] srcc_idx_o,
  output logic             wa_en_o,
  output logic [IDX_W-1:0] wa_idx_o,
  output logic [XLEN-1:0]  wa_data_o,
  output logic             wd_en_o,
  output logic [IDX_W-1:0] wd_idx_o,
  output logic [XLEN-1:0]  wd_data_o
);
  localparam int unsigned HALF = LANES / 2;

  dec_t                    dec;
  logic [LANES*PROD_W-1:0] prods;
  logic [XLEN-1:0]         res_a;
  logic [XLEN-1:0]         res_d;

  qmul_decode u_dec (
    .valid_i (valid_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  assign srcb_idx_o = dec.sb;
  assign srcc_idx_o = dec.sc;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    qmul_lane #(.LANE_W(LANE_W), .PROD_W(PROD_W)) u_lane (
      .b_i        (opb_i[i*LANE_W +: LANE_W]),
      .c_i        (opc_i[i*LANE_W +: LANE_W]),
      .b_signed_i (dec.b_signed),
      .prod_o     (prods[i*PROD_W +: PROD_W])
    );
  end

  // lower lanes to D, upper lanes to A
  assign res_d = prods[0 +: HALF*PROD_W];
  assign res_a = prods[HALF*PROD_W +: HALF*PROD_W];

  qmul_wb_reg u_wb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dec_i     (dec),
    .res_a_i   (res_a),
    .res_d_i   (res_d),
    .wa_en_o   (wa_en_o),
    .wa_idx_o  (wa_idx_o),
    .wa_data_o (wa_data_o),
    .wd_en_o   (wd_en_o),
    .wd_idx_o  (wd_idx_o),
    .wd_data_o (wd_data_o)
  );
endmodule

// File: rtl/qmul_unit_chk.sv
module qmul_unit_chk
  import qmul_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [XLEN-1:0]  instr_i,
  input logic [XLEN-1:0]  opc_i,
  input logic             wa_en_o,
  input logic [IDX_W-1:0] wa_idx_o,
  input logic [XLEN-1:0]  wa_data_o,
  input logic             wd_en_o,
  input logic [IDX_W-1:0] wd_idx_o,
  input logic [XLEN-1:0]  wd_data_o
);
  logic issue;
  assign issue = valid_i && (instr_i[31:26] == MAJOR_OP) && (instr_i[5:0] == FUNC_OP);

  AST_EN_AFTER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wa_en_o == $past(issue)); // R2

  AST_D_NEEDS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_en_o |-> wa_en_o); // R2

  AST_SAME_DEST_A_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa_en_o && wa_idx_o == wd_idx_o) |-> !wd_en_o); // R9

  AST_DIFF_DEST_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa_en_o && wa_idx_o != wd_idx_o) |-> wd_en_o); // R9

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(issue) |-> ($stable(wa_data_o) && $stable(wd_data_o))); // R11

  AST_ZERO_C_LANE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(issue && opc_i[7:0] == 8'h00) |-> (wd_data_o[15:0] == 16'h0000)); // R6

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (!wa_en_o && !wd_en_o && wa_data_o == '0 && wd_data_o == '0); // R10
    end
  end
endmodule

bind qmul_unit qmul_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .instr_i   (instr_i),
  .opc_i     (opc_i),
  .wa_en_o   (wa_en_o),
  .wa_idx_o  (wa_idx_o),
  .wa_data_o (wa_data_o),
  .wd_en_o   (wd_en_o),
  .wd_idx_o  (wd_idx_o),
  .wd_data_o (wd_data_o)
);

// File: tb/qmul_unit_tb_top.sv
`timescale 1ns/1ps
module qmul_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] opb_i = '0;
  logic [31:0] opc_i = '0;
  logic [3:0]  srcb_idx_o, srcc_idx_o, wa_idx_o, wd_idx_o;
  logic        wa_en_o, wd_en_o;
  logic [31:0] wa_data_o, wd_data_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_a = '0;
  logic [31:0] last_d = '0;

  always #2.5 clk = ~clk;

  qmul_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .opb_i(opb_i), .opc_i(opc_i), .srcb_idx_o(srcb_idx_o), .srcc_idx_o(srcc_idx_o),
    .wa_en_o(wa_en_o), .wa_idx_o(wa_idx_o), .wa_data_o(wa_data_o),
    .wd_en_o(wd_en_o), .wd_idx_o(wd_idx_o), .wd_data_o(wd_data_o)
  );

  function automatic logic [31:0] mk(logic [5:0] maj, logic [5:0] fn, logic [3:0] sel,
                                     logic [3:0] a, logic [3:0] b, logic [3:0] c, logic [3:0] d);
    return {maj, sel, d, c, b, a, fn};
  endfunction

  function automatic logic [15:0] ref_lane(logic [7:0] b, logic [7:0] c, bit sgn);
    int bb = sgn ? int'($signed(b)) : int'(b);
    int pr = bb * int'(c);
    return pr[15:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] ins, logic [31:0] b, logic [31:0] c, bit vld);
    bit hit = vld && ins[31:26] == 6'h1C && ins[5:0] == 6'h38;
    bit sgn = ins[25:22] == 4'd2;
    logic [31:0] ea, ed;
    @(negedge clk);
    valid_i = vld; instr_i = ins; opb_i = b; opc_i = c;
    #1;
    chk("R3 srcb_idx", 32'(srcb_idx_o), 32'(ins[13:10]));
    chk("R3 srcc_idx", 32'(srcc_idx_o), 32'(ins[17:14]));
    ed = {ref_lane(b[15:8], c[15:8], sgn), ref_lane(b[7:0], c[7:0], sgn)};
    ea = {ref_lane(b[31:24], c[31:24], sgn), ref_lane(b[23:16], c[23:16], sgn)};
    @(negedge clk);
    valid_i = 1'b0;
    if (hit) begin
      last_a = ea; last_d = ed;
      chk("R2 wa_en", 32'(wa_en_o), 32'd1);
      chk("R9 wd_en", 32'(wd_en_o), 32'(ins[9:6] != ins[21:18]));
      chk("R3 wa_idx", 32'(wa_idx_o), 32'(ins[9:6]));
      chk("R3 wd_idx", 32'(wd_idx_o), 32'(ins[21:18]));
      chk("R8 R4 R5 R6 wa_data", wa_data_o, ea);
      chk("R7 R4 R5 R6 wd_data", wd_data_o, ed);
    end else begin
      chk("R1 wa_en", 32'(wa_en_o), 32'd0);
      chk("R1 wd_en", 32'(wd_en_o), 32'd0);
      chk("R11 wa_data hold", wa_data_o, last_a);
      chk("R11 wd_data hold", wd_data_o, last_d);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ext [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    void'($urandom(32'h5EED_1234));
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 wa_en", 32'(wa_en_o), 32'd0);
    chk("R10 wd_en", 32'(wd_en_o), 32'd0);
    chk("R10 wa_data", wa_data_o, 32'd0);
    chk("R10 wd_data", wd_data_o, 32'd0);
    rst_ni = 1'b1;

    // R4 R5 byte extremes, uniform and rotated across lanes
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          issue(mk(6'h1C, 6'h38, 4'(s), 4'd1, 4'd2, 4'd3, 4'd4),
                {4{ext[i]}}, {4{ext[j]}}, 1'b1);
          issue(mk(6'h1C, 6'h38, 4'(s), 4'd5, 4'd6, 4'd7, 4'd8),
                {ext[i], ext[(i+1)%4], ext[(i+2)%4], ext[(i+3)%4]},
                {ext[(j+3)%4], ext[j], ext[(j+1)%4], ext[(j+2)%4]}, 1'b1);
        end

    // R9 same destination
    issue(mk(6'h1C, 6'h38, 4'd2, 4'd9, 4'd9, 4'd3, 4'd9), 32'h80FF7F01, 32'hFF80FF02, 1'b1);
    issue(mk(6'h1C, 6'h38, 4'd0, 4'd0, 4'd1, 4'd1, 4'd0), 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);

    // R1 near-miss opcodes and invalid strobe
    issue(mk(6'h1D, 6'h38, 4'd2, 4'd1, 4'd2, 4'd3, 4'd4), 32'h12345678, 32'h9ABCDEF0, 1'b1);
    issue(mk(6'h1C, 6'h39, 4'd2, 4'd1, 4'd2, 4'd3, 4'd4), 32'h12345678, 32'h9ABCDEF0, 1'b1);
    issue(mk(6'h1C, 6'h38, 4'd2, 4'd1, 4'd2, 4'd3, 4'd4), 32'h12345678, 32'h9ABCDEF0, 1'b0);

    // R11 operands change while idle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      opb_i = $urandom; opc_i = $urandom;
      @(negedge clk);
      chk("R11 idle wa_data", wa_data_o, last_a);
      chk("R11 idle wd_data", wd_data_o, last_d);
      chk("R2 idle wa_en", 32'(wa_en_o), 32'd0);
    end

    // random mix
    for (int n = 0; n < 500; n++) begin
      logic [31:0] ins = $urandom;
      if ($urandom_range(0, 9) != 0) begin
        ins[31:26] = 6'h1C; ins[5:0] = 6'h38;
      end
      if ($urandom_range(0, 3) == 0) ins[25:22] = 4'd2;
      issue(ins, $urandom, $urandom, $urandom_range(0, 7) != 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule